// File: doc/BRIEF.md
# SMBus Block Transfer Engine

This block is the host-side sequencer for SMBus block write and block read transactions. It does not handle bit timing. It drives a byte-level link layer through a request/complete handshake. The operations on that link are a start or repeated start, a stop, a byte write that returns the target's acknowledge, and a byte read that carries the acknowledge or not-acknowledge the host should send. Software supplies the target address, the command code, the direction, and, for a write, the byte count. It then pulses `go`. The engine accepts counts from 1 to 32. It applies the same range to the count byte that the target returns during a read.

Data moves in one of two ways. With `buf_en` set and `i2c_mode` clear, a 32-entry byte queue holds the whole payload. For a write, software fills the queue before `go`. For a read, the queue fills as bytes arrive and software drains it after completion. In this mode the interrupt fires only when the transfer has finished. In every other case the engine works in single-byte mode, and it stalls with `irq` raised on each data byte. It stays stalled until software supplies the next byte (`sw_wpush`) or takes the received one (`sw_rpop`). A write that requests I2C mode together with PEC/auto-append is refused before any link activity.

The state machine has these states:
- IDLE.
- START, then ADDR_W, then CMD.
- On the write path: CNT_TX, then NEED_TX (stall for a byte) alternating with DATA_TX.
- On the read path: RSTART, ADDR_R, CNT_RX, then DATA_RX alternating with HOLD_RX (stall for a drain).
- STOP.

The transitions are:
- IDLE moves to START on an accepted `go`.
- Each link state advances when `lk_done` arrives.
- A not-acknowledged write in any state moves to STOP.
- CMD branches to RSTART for a read and to CNT_TX for a write.
- CNT_TX moves to DATA_TX when the queue is in use, and to NEED_TX otherwise.
- NEED_TX moves to DATA_TX on `sw_wpush`.
- DATA_TX moves to STOP after the last byte.
- CNT_RX moves to STOP if the received count is out of range.
- DATA_RX moves to HOLD_RX in single-byte mode. In queued mode it loops until the last byte and then moves to STOP.
- HOLD_RX moves to DATA_RX on `sw_rpop`, or to STOP if no bytes remain.
- STOP returns to IDLE and sets `done`.

Top module: `smb_blk_engine`

## Requirements
- R1: A write transaction issues, in order: START, WRITE of `{addr,0}`, WRITE of the command, WRITE of the count, one WRITE per data byte, then STOP. On the link, `lk_cmd` is encoded as 0=START, 1=STOP, 2=WRITE, 3=READ.
- R2: A read transaction issues, in order: START, WRITE `{addr,0}`, WRITE command, START, WRITE `{addr,1}`, READ (the count), then N READs and STOP. Here N is the received count. `lk_nack` is 1 only on the final data READ and only ever with a READ.
- R3: A `go` for a write with a count of 0 or greater than 32 makes no link request and sets `done` and `err` in the next cycle.
- R4: A `go` for a write with both `i2c_mode` and `pec_en` set is refused in the same way. `pec_en` alone does not refuse a write.
- R5: In queued mode (`buf_en`=1, `i2c_mode`=0), `irq` stays low from the accepted `go` until completion. Write data comes from the queue in push order. Received data can be popped from the queue in arrival order after `done`.
- R6: In single-byte write mode, before each data byte the engine raises `irq`, keeps `lk_valid` low, and waits for `sw_wpush`. The byte pushed is the byte sent.
- R7: In single-byte read mode, each received byte is presented on `sw_rdata` with `irq` high. The engine waits for `sw_rpop` before the next READ.
- R8: With `i2c_mode` set, the engine uses single-byte mode even when `buf_en` is set.
- R9: A received count of 0 or greater than 32 is followed directly by STOP, with no data READ, and sets `err`.
- R10: A not-acknowledge on any WRITE is followed directly by STOP and sets `err`.
- R11: Once `lk_valid` is raised, `lk_valid`, `lk_cmd` and `lk_wbyte` hold steady until `lk_done`.
- R12: After reset, `lk_valid`, `irq`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse, accepted only in IDLE |
| rd_mode | input | 1 | 1 = block read, 0 = block write |
| slv_addr | input | 7 | Target address |
| cmd_code | input | 8 | Command byte |
| wr_count | input | 8 | Byte count for a write |
| buf_en | input | 1 | Request the 32-byte queue |
| i2c_mode | input | 1 | I2C mode, which forces single-byte operation |
| pec_en | input | 1 | PEC/auto-append requested |
| sw_wdata | input | 8 | Software write byte |
| sw_wpush | input | 1 | Push to the queue in IDLE, or supply the byte in NEED_TX |
| sw_rdata | output | 8 | Received byte (HOLD_RX) or queue head |
| sw_rpop | input | 1 | Pop the queue in IDLE, or release HOLD_RX |
| irq | output | 1 | Completion or per-byte service request |
| done | output | 1 | Last transaction finished or refused |
| err | output | 1 | Last transaction refused or aborted |
| lk_valid | output | 1 | Link request pending |
| lk_cmd | output | 2 | Link operation code |
| lk_wbyte | output | 8 | Byte to write |
| lk_nack | output | 1 | Send not-acknowledge after this READ |
| lk_done | input | 1 | Link operation complete (one cycle) |
| lk_ack | input | 1 | Target acknowledged the WRITE |
| lk_rbyte | input | 8 | Byte returned by a READ |

## Verification
Some properties are checked on every cycle:
- A pending link request holds steady until it completes.
- `lk_nack` appears only with a READ.
- In queued mode, `irq` stays quiet while a transaction is under way.
- The queue level and the remaining-byte counter never leave their range, and the counter never decrements at zero.

Other behaviour can only be shown by the bench's scenarios, because it depends on whole transactions:
- The exact order and content of link operations.
- Where STOP cuts in after a refused count or a not-acknowledge.
- That the bytes software pushes or pops match the bytes on the link.
- That refused writes leave the link untouched.

The bench sweeps every legal count in queued mode for both directions, and checks the out-of-range counts on each side of the limits.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;

    typedef enum logic [1:0] {
        LK_START = 2'd0,
        LK_STOP  = 2'd1,
        LK_WRITE = 2'd2,
        LK_READ  = 2'd3
    } lk_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR_W,
        ST_CMD,
        ST_CNT_TX,
        ST_NEED_TX,
        ST_DATA_TX,
        ST_RSTART,
        ST_ADDR_R,
        ST_CNT_RX,
        ST_DATA_RX,
        ST_HOLD_RX,
        ST_STOP
    } eng_state_e;

endpackage

// File: rtl/smb_blk_buf.sv
// Byte queue; DEPTH must be a power of two.
module smb_blk_buf #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp, lvl;
    logic         full;

    assign lvl   = wp - rp;
    assign empty = (lvl == '0);
    assign full  = (lvl == (AW+1)'(DEPTH));
    assign dout  = mem[rp[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else if (flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) wp <= wp + 1'b1;
            if (pop && !empty) rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full && !flush) mem[wp[AW-1:0]] <= din;
    end

    AST_LVL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= (AW+1)'(DEPTH)); // R5

endmodule

// File: rtl/smb_blk_cnt.sv
// Remaining-byte counter with count range check.
module smb_blk_cnt #(
    parameter int MAXB = 32,
    parameter int VW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [VW-1:0] load_val,
    input  logic          dec,
    input  logic [VW-1:0] chk_val,
    output logic          chk_ok,
    output logic [VW-1:0] rem,
    output logic          last,
    output logic          zero
);
    localparam logic [VW-1:0] LIMIT = VW'(MAXB);

    assign chk_ok = (chk_val != '0) && (chk_val <= LIMIT);
    assign last   = (rem == VW'(1));
    assign zero   = (rem == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rem <= '0;
        else if (load)             rem <= load_val;
        else if (dec && rem != '0) rem <= rem - 1'b1;
    end

    AST_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rem <= LIMIT); // R3
    AST_DEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> rem != '0); // R1

endmodule

// File: rtl/smb_blk_engine.sv
module smb_blk_engine
    import smb_blk_pkg::*;
#(
    parameter int MAXB = 32,
    parameter int BW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          rd_mode,
    input  logic [6:0]    slv_addr,
    input  logic [BW-1:0] cmd_code,
    input  logic [BW-1:0] wr_count,
    input  logic          buf_en,
    input  logic          i2c_mode,
    input  logic          pec_en,
    input  logic [BW-1:0] sw_wdata,
    input  logic          sw_wpush,
    output logic [BW-1:0] sw_rdata,
    input  logic          sw_rpop,
    output logic          irq,
    output logic          done,
    output logic          err,
    output logic          lk_valid,
    output logic [1:0]    lk_cmd,
    output logic [BW-1:0] lk_wbyte,
    output logic          lk_nack,
    input  logic          lk_done,
    input  logic          lk_ack,
    input  logic [BW-1:0] lk_rbyte
);
    eng_state_e state_q, state_d;

    logic [6:0]    addr_q;
    logic [BW-1:0] cmd_q, tx_q, rx_q;
    logic          rd_q, ubuf_q, done_q, err_q;

    logic [BW-1:0] cnt_val, cnt_rem, buf_dout, buf_din;
    logic          cnt_ok, cnt_last, cnt_zero, cnt_load, cnt_dec;
    logic          buf_empty, buf_push, buf_pop, buf_flush;
    logic          is_idle, refuse, start_ok, nack_evt, bad_rx_cnt;

    assign is_idle    = (state_q == ST_IDLE);
    assign cnt_val    = is_idle ? wr_count : lk_rbyte;
    assign refuse     = !rd_mode && (!cnt_ok || (i2c_mode && pec_en));
    assign start_ok   = is_idle && go && !refuse;
    assign nack_evt   = lk_done && lk_valid && (lk_cmd == LK_WRITE) && !lk_ack;
    assign bad_rx_cnt = (state_q == ST_CNT_RX) && lk_done && !cnt_ok;

    assign cnt_load = (start_ok && !rd_mode) ||
                      ((state_q == ST_CNT_RX) && lk_done && cnt_ok);
    assign cnt_dec  = lk_done && ((state_q == ST_DATA_TX) || (state_q == ST_DATA_RX));

    assign buf_flush = start_ok && rd_mode;
    assign buf_push  = (is_idle && sw_wpush) ||
                       ((state_q == ST_DATA_RX) && lk_done && ubuf_q);
    assign buf_din   = is_idle ? sw_wdata : lk_rbyte;
    assign buf_pop   = (is_idle && sw_rpop) ||
                       ((state_q == ST_DATA_TX) && lk_done && ubuf_q);

    smb_blk_cnt #(.MAXB(MAXB), .VW(BW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .chk_val  (cnt_val),
        .chk_ok   (cnt_ok),
        .rem      (cnt_rem),
        .last     (cnt_last),
        .zero     (cnt_zero)
    );

    smb_blk_buf #(.DEPTH(MAXB), .W(BW)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (buf_flush),
        .push  (buf_push),
        .din   (buf_din),
        .pop   (buf_pop),
        .dout  (buf_dout),
        .empty (buf_empty)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_ok) state_d = ST_START;
            ST_START:   if (lk_done)  state_d = ST_ADDR_W;
            ST_ADDR_W:  if (lk_done)  state_d = !lk_ack ? ST_STOP : ST_CMD;
            ST_CMD:     if (lk_done)  state_d = !lk_ack ? ST_STOP :
                                                (rd_q ? ST_RSTART : ST_CNT_TX);
            ST_CNT_TX:  if (lk_done)  state_d = !lk_ack ? ST_STOP :
                                                (ubuf_q ? ST_DATA_TX : ST_NEED_TX);
            ST_NEED_TX: if (sw_wpush) state_d = ST_DATA_TX;
            ST_DATA_TX: if (lk_done)  state_d = (!lk_ack || cnt_last) ? ST_STOP :
                                                (ubuf_q ? ST_DATA_TX : ST_NEED_TX);
            ST_RSTART:  if (lk_done)  state_d = ST_ADDR_R;
            ST_ADDR_R:  if (lk_done)  state_d = !lk_ack ? ST_STOP : ST_CNT_RX;
            ST_CNT_RX:  if (lk_done)  state_d = cnt_ok ? ST_DATA_RX : ST_STOP;
            ST_DATA_RX: if (lk_done)  state_d = !ubuf_q ? ST_HOLD_RX :
                                                (cnt_last ? ST_STOP : ST_DATA_RX);
            ST_HOLD_RX: if (sw_rpop)  state_d = cnt_zero ? ST_STOP : ST_DATA_RX;
            ST_STOP:    if (lk_done)  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transaction context and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
            rd_q   <= 1'b0;
            ubuf_q <= 1'b0;
            tx_q   <= '0;
            rx_q   <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (start_ok) begin
                addr_q <= slv_addr;
                cmd_q  <= cmd_code;
                rd_q   <= rd_mode;
                ubuf_q <= buf_en && !i2c_mode;
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end else if (is_idle && go) begin
                done_q <= 1'b1;
                err_q  <= 1'b1;
            end
            if (nack_evt || bad_rx_cnt)                err_q  <= 1'b1;
            if ((state_q == ST_STOP) && lk_done)       done_q <= 1'b1;
            if ((state_q == ST_NEED_TX) && sw_wpush)   tx_q   <= sw_wdata;
            if ((state_q == ST_DATA_RX) && lk_done && !ubuf_q) rx_q <= lk_rbyte;
        end
    end

    // Output logic
    always_comb begin
        lk_valid = 1'b0;
        lk_cmd   = LK_START;
        lk_wbyte = '0;
        lk_nack  = 1'b0;
        unique case (state_q)
            ST_START, ST_RSTART: begin
                lk_valid = 1'b1;
                lk_cmd   = LK_START;
            end
            ST_ADDR_W: begin
                lk_valid = 1'b1;
                lk_cmd   = LK_WRITE;
                lk_wbyte = {addr_q, 1'b0};
            end
            ST_ADDR_R: begin
                lk_valid = 1'b1;
                lk_cmd   = LK_WRITE;
                lk_wbyte = {addr_q, 1'b1};
            end
            ST_CMD: begin
                lk_valid = 1'b1;
                lk_cmd   = LK_WRITE;
                lk_wbyte = cmd_q;
            end
            ST_CNT_TX: begin
                lk_valid = 1'b1;
                lk_cmd   = LK_WRITE;
                lk_wbyte = cnt_rem;
            end
            ST_DATA_TX: begin
                lk_valid = ubuf_q ? !buf_empty : 1'b1;
                lk_cmd   = LK_WRITE;
                lk_wbyte = ubuf_q ? buf_dout : tx_q;
            end
            ST_CNT_RX: begin
                lk_valid = 1'b1;
                lk_cmd   = LK_READ;
            end
            ST_DATA_RX: begin
                lk_valid = 1'b1;
                lk_cmd   = LK_READ;
                lk_nack  = cnt_last;
            end
            ST_STOP: begin
                lk_valid = 1'b1;
                lk_cmd   = LK_STOP;
            end
            default: ;
        endcase
    end

    assign irq      = done_q || (state_q == ST_NEED_TX) || (state_q == ST_HOLD_RX);
    assign done     = done_q;
    assign err      = err_q;
    assign sw_rdata = (state_q == ST_HOLD_RX) ? rx_q : buf_dout;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_done) |=> (lk_valid && $stable(lk_cmd) && $stable(lk_wbyte))); // R11
    AST_NACK_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_nack) |-> (lk_cmd == LK_READ)); // R2
    AST_BUF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_idle && ubuf_q) |-> !irq); // R5
    AST_STOP_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        nack_evt |=> (lk_valid && lk_cmd == LK_STOP)); // R10

endmodule

// File: tb/smb_blk_engine_tb.sv
module smb_blk_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 0, rd_mode = 0, buf_en = 0, i2c_mode = 0, pec_en = 0;
    logic [6:0] slv_addr = '0;
    logic [7:0] cmd_code = '0, wr_count = '0, sw_wdata = '0;
    logic       sw_wpush = 0, sw_rpop = 0;
    logic [7:0] sw_rdata;
    logic       irq, done, err;
    logic       lk_valid, lk_nack;
    logic [1:0] lk_cmd;
    logic [7:0] lk_wbyte;
    logic       lk_done = 0, lk_ack = 0;
    logic [7:0] lk_rbyte = '0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int log_n = 0, exp_n = 0;
    int log_e [0:99];
    int exp_e [0:99];
    int wr_idx = 0, rd_idx = 0, nack_w = -1, resp_cnt = 0, lat_lim = 0, lat = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_blk_engine u_dut (
        .clk(clk), .rst_n(rst_n), .go(go), .rd_mode(rd_mode), .slv_addr(slv_addr),
        .cmd_code(cmd_code), .wr_count(wr_count), .buf_en(buf_en), .i2c_mode(i2c_mode),
        .pec_en(pec_en), .sw_wdata(sw_wdata), .sw_wpush(sw_wpush), .sw_rdata(sw_rdata),
        .sw_rpop(sw_rpop), .irq(irq), .done(done), .err(err), .lk_valid(lk_valid),
        .lk_cmd(lk_cmd), .lk_wbyte(lk_wbyte), .lk_nack(lk_nack), .lk_done(lk_done),
        .lk_ack(lk_ack), .lk_rbyte(lk_rbyte)
    );

    function automatic logic [7:0] dat(int k);
        return 8'((60 + 5 * k) % 256);
    endfunction

    function automatic int enc(int c, int nk, int b);
        return c * 512 + nk * 256 + b;
    endfunction

    // Link layer model: completes each request after lat_lim idle cycles
    always @(posedge clk) begin
        lk_done <= 1'b0;
        if (rst_n && lk_valid && !lk_done) begin
            if (lat >= lat_lim) begin
                lat = 0;
                lk_done <= 1'b1;
                log_e[log_n] = enc(int'(lk_cmd), int'(lk_nack),
                                   (lk_cmd == 2'd2) ? int'(lk_wbyte) : 0);
                if (log_n < 99) log_n++;
                if (lk_cmd == 2'd2) begin
                    lk_ack <= (wr_idx != nack_w);
                    wr_idx++;
                end
                if (lk_cmd == 2'd3) begin
                    lk_rbyte <= (rd_idx == 0) ? 8'(resp_cnt) : dat(rd_idx - 1);
                    rd_idx++;
                end
            end else begin
                lat++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_log(input string req);
        int bad = -1;
        for (int i = 0; i < exp_n; i++)
            if (bad < 0 && (i >= log_n || log_e[i] != exp_e[i])) bad = i;
        if (bad < 0 && log_n != exp_n) bad = exp_n;
        if (bad < 0) chk(1'b1, req, "link sequence", 0, 0);
        else if (bad >= log_n || bad >= exp_n) chk(1'b0, req, "link sequence length", log_n, exp_n);
        else chk(1'b0, req, "link entry", log_e[bad], exp_e[bad]);
    endtask

    task automatic add(input int v);
        exp_e[exp_n] = v;
        exp_n++;
    endtask

    task automatic pulse_go();
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
    endtask

    task automatic run_write(input int n, input bit b, input bit i2c, input bit pec,
                             input int nw, input int lt, input string req);
        bit eff, refused;
        int reqs, bad_irq, bad_link, w, wait_c;
        eff = b && !i2c;
        refused = (n < 1) || (n > 32) || (i2c && pec);
        @(negedge clk);
        log_n = 0; wr_idx = 0; nack_w = nw; lat_lim = lt; lat = 0;
        rd_mode = 0; buf_en = b; i2c_mode = i2c; pec_en = pec;
        slv_addr = 7'(16 + n); cmd_code = 8'(200 - n); wr_count = 8'(n);
        if (eff && !refused)
            for (int k = 0; k < n; k++) begin
                sw_wdata = dat(k); sw_wpush = 1'b1;
                @(negedge clk); sw_wpush = 1'b0;
            end
        pulse_go();
        reqs = 0; bad_irq = 0; bad_link = 0; wait_c = 0;
        while (!done && wait_c < 4000) begin
            if (irq) begin
                if (eff) bad_irq++;
                if (lk_valid) bad_link++;
                sw_wdata = dat(reqs); sw_wpush = 1'b1;
                @(negedge clk); sw_wpush = 1'b0;
                reqs++;
            end else begin
                @(negedge clk);
            end
            wait_c++;
        end
        exp_n = 0;
        if (!refused) begin
            add(enc(0, 0, 0));
            for (int j = 0; j < n + 3; j++) begin
                w = (j == 0) ? int'({slv_addr, 1'b0}) : (j == 1) ? int'(cmd_code) :
                    (j == 2) ? n : int'(dat(j - 3));
                add(enc(2, 0, w));
                if (j == nw) break;
            end
            add(enc(1, 0, 0));
        end
        chk_log(req);
        chk(done == 1'b1, req, "done", int'(done), 1);
        chk(err == (refused || nw >= 0), req, "err", int'(err), int'(refused || nw >= 0));
        if (eff) chk(bad_irq == 0, req, "irq during queued write", bad_irq, 0);
        else if (!refused && nw < 0) begin
            chk(reqs == n && bad_link == 0, req, "byte requests (link idle while waiting)",
                reqs * 100 + bad_link, n * 100);
        end
    endtask

    task automatic run_read(input int n, input bit b, input bit i2c, input int lt, input string req);
        bit eff, ok;
        int reqs, bad_irq, bad_dat, wait_c;
        eff = b && !i2c;
        ok = (n >= 1) && (n <= 32);
        @(negedge clk);
        log_n = 0; wr_idx = 0; rd_idx = 0; nack_w = -1; resp_cnt = n; lat_lim = lt; lat = 0;
        rd_mode = 1; buf_en = b; i2c_mode = i2c; pec_en = 0;
        slv_addr = 7'(90 - (n % 64)); cmd_code = 8'(n + 7); wr_count = 8'd0;
        pulse_go();
        reqs = 0; bad_irq = 0; bad_dat = 0; wait_c = 0;
        while (!done && wait_c < 4000) begin
            if (irq) begin
                if (eff) bad_irq++;
                if (sw_rdata != dat(reqs)) bad_dat++;
                sw_rpop = 1'b1;
                @(negedge clk); sw_rpop = 1'b0;
                reqs++;
            end else begin
                @(negedge clk);
            end
            wait_c++;
        end
        if (eff && ok)
            for (int k = 0; k < n; k++) begin
                if (sw_rdata != dat(k)) bad_dat++;
                sw_rpop = 1'b1;
                @(negedge clk); sw_rpop = 1'b0;
            end
        exp_n = 0;
        add(enc(0, 0, 0));
        add(enc(2, 0, int'({slv_addr, 1'b0})));
        add(enc(2, 0, int'(cmd_code)));
        add(enc(0, 0, 0));
        add(enc(2, 0, int'({slv_addr, 1'b1})));
        add(enc(3, 0, 0));
        if (ok) for (int k = 0; k < n; k++) add(enc(3, (k == n - 1) ? 1 : 0, 0));
        add(enc(1, 0, 0));
        chk_log(req);
        chk(err == !ok, req, "err", int'(err), int'(!ok));
        chk(bad_dat == 0, req, "received data mismatches", bad_dat, 0);
        if (eff) chk(bad_irq == 0, req, "irq during queued read", bad_irq, 0);
        else chk(reqs == (ok ? n : 0), req, "byte-ready events", reqs, ok ? n : 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset values
        chk(!lk_valid && !irq && !done && !err, "R12", "reset outputs",
            {lk_valid, irq, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!lk_valid && !irq, "R12", "idle after reset", {lk_valid, irq}, 0);

        // R1 R5 R11: queued write, every legal count, varying link latency
        for (int n = 1; n <= 32; n++) run_write(n, 1, 0, 0, -1, n % 3, "R1/R5/R11");
        // R6: single-byte write
        run_write(1, 0, 0, 0, -1, 1, "R6");
        run_write(2, 0, 0, 0, -1, 0, "R6");
        run_write(7, 0, 0, 0, -1, 2, "R6");
        // R8: I2C forces single-byte mode
        run_write(4, 1, 1, 0, -1, 1, "R8");
        // R3: out-of-range write counts
        run_write(0, 1, 0, 0, -1, 0, "R3");
        run_write(33, 1, 0, 0, -1, 0, "R3");
        run_write(255, 0, 0, 0, -1, 0, "R3");
        // R4: I2C with PEC refused; PEC alone accepted
        run_write(3, 0, 1, 1, -1, 0, "R4");
        run_write(3, 1, 0, 1, -1, 0, "R4");
        // R10: not-acknowledge on address and on a data byte
        run_write(3, 0, 0, 0, 0, 0, "R10");
        run_write(3, 0, 0, 0, 4, 1, "R10");
        // R2 R5: queued read, every legal count
        for (int n = 1; n <= 32; n++) run_read(n, 1, 0, (n + 1) % 3, "R2/R5");
        // R7: single-byte read
        run_read(1, 0, 0, 0, "R7");
        run_read(2, 0, 0, 2, "R7");
        run_read(5, 0, 0, 1, "R7");
        // R8: I2C read uses single-byte path
        run_read(3, 1, 1, 0, "R8");
        // R9: bad received counts
        run_read(0, 1, 0, 0, "R9");
        run_read(33, 1, 0, 1, "R9");
        run_read(255, 0, 0, 0, "R9");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule